// File: doc/BRIEF.md
# GPIO Port Register File

This block is the software-visible register file of a 16-pin general-purpose I/O port. A 32-bit register interface writes and reads the port's configuration: per-pin direction mode, output type, drive speed, pull selection, output data, a lock word, two alternate-function selection words and an analog-switch word. Direction, output type, speed, pull and output data leave the block as flat vectors that feed a companion pin resolver. The resolver works out the pin levels and returns them as the input-data word. Software reads that word here.

Output data can be changed in three ways. A plain write replaces it. A set/reset port changes selected bits atomically, and a set request beats a clear request on the same pin. A clear-only port clears selected bits. The resolver receives a one-cycle update pulse after each write that can change configuration or output data, so it recomputes the pin state in the next cycle. The lock, alternate-function, speed and analog registers are only stored and read back; no behaviour hangs on them here.

Top module: `gpio_port_regs`

## Requirements
- R1: After rst_ni is released, mode, speed and pull read back their reset parameters (defaults 0xFFFFFFFF, 0x0C000000, 0x64000000). Output type, output data, lock, both alternate-function words and analog switch read back zero, and upd_o is 0.
- R2: The registers at byte offsets 0x00 (mode), 0x08 (speed), 0x0C (pull), 0x20 (alternate function, pins 0-7) and 0x24 (alternate function, pins 8-15) store and read back all 32 bits of a write.
- R3: Writes to 0x04 (output type), 0x14 (output data), 0x1C (lock) and 0x2C (analog switch) keep wdata_i[15:0] and discard bits 31:16, which read back as zero.
- R4: A write to 0x18 clears each output-data bit n where wdata_i[16+n] is 1 and sets each bit n where wdata_i[n] is 1. When both are 1 for one pin, the bit ends at 1. Other bits keep their value.
- R5: A write to 0x28 clears each output-data bit n where wdata_i[n] is 1, ignores wdata_i[31:16] and leaves the other bits unchanged.
- R6: Reads of 0x18 and 0x28 return zero.
- R7: A read of 0x10 returns pin_in_i zero-extended, as sampled in the read cycle. A write to 0x10 changes no register and raises no update pulse.
- R8: Accesses are aligned 32-bit only. An address with bits 1:0 not zero, or a word offset above 0x2C, reads as zero and ignores writes.
- R9: rdata_o takes the read value on the clock edge that samples rd_en_i, so it is valid in the following cycle. It holds its value while rd_en_i is low.
- R10: upd_o is high for exactly the cycle after each write to a mapped offset other than 0x10, and low after any cycle without such a write.
- R11: mode_o, otype_o, speed_o, pull_o and odata_o always show the current mode, output-type, speed, pull and output-data register contents. Encodings passed through: mode 2 bits per pin (01 = output), pull 2 bits per pin (01 = up, 10 = down), output type 1 bit per pin (1 = open-drain).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pin_in_i | input | NUM_PINS | Resolved pin levels from the pin resolver |
| mode_o | output | 2*NUM_PINS | Per-pin mode field |
| otype_o | output | NUM_PINS | Per-pin output type |
| speed_o | output | 2*NUM_PINS | Per-pin speed field |
| pull_o | output | 2*NUM_PINS | Per-pin pull field |
| odata_o | output | NUM_PINS | Output-data word |
| upd_o | output | 1 | One-cycle pulse after a configuration or output-data write |

## Verification
The properties assume that wr_en_i and rd_en_i are single-cycle strobes with addr_i and wdata_i stable and known while a strobe is high. They also assume the pin resolver holds pin_in_i steady around the sampling edge of a read. The stimulus changes every input on the falling clock edge and raises at most one strobe at a time, each for one cycle. So the set/reset and clear checks see the write data they relate to, and the hold check on rdata_o is never broken by a read overlapping a write.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = DATA_W / 2;
  localparam int NUM_REGS = 12;

  // Word index = byte offset / 4; the decode depends on this order.
  typedef enum logic [3:0] {
    RI_MODE  = 4'd0,
    RI_OTYPE = 4'd1,
    RI_SPEED = 4'd2,
    RI_PULL  = 4'd3,
    RI_IDATA = 4'd4,
    RI_ODATA = 4'd5,
    RI_BSR   = 4'd6,
    RI_LOCK  = 4'd7,
    RI_AFLO  = 4'd8,
    RI_AFHI  = 4'd9,
    RI_BCLR  = 4'd10,
    RI_ASW   = 4'd11
  } reg_idx_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel_o[g] = aligned && (addr_i[ADDR_W-1:2] == WORD_W'(g));
  end
endmodule

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg #(
  parameter int           WIDTH = 32,
  parameter logic [WIDTH-1:0] RST = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/gpio_odata_ctrl.sv
module gpio_odata_ctrl
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_full_i,
  input  logic              wr_bsr_i,
  input  logic              wr_bclr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NUM_PINS-1:0] odata_o
);
  logic [NUM_PINS-1:0] set_m, clr_m;
  assign set_m = wdata_i[NUM_PINS-1:0];
  assign clr_m = wdata_i[HALF_W +: NUM_PINS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        odata_o <= '0;
    else if (wr_full_i) odata_o <= set_m;
    else if (wr_bsr_i)  odata_o <= (odata_o & ~clr_m) | set_m;  // set applied last: wins
    else if (wr_bclr_i) odata_o <= odata_o & ~set_m;
  end
endmodule

// File: rtl/gpio_rdata_mux.sv
module gpio_rdata_mux
  import gpio_regs_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic [NUM_REGS-1:0] sel_i,
  input  logic [DATA_W-1:0]   words_i [NUM_REGS],
  output logic [DATA_W-1:0]   rdata_o
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel_i[i]) rd_next = rd_next | words_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_next;
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_regs_pkg::*;
#(
  parameter int          NUM_PINS  = 16,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] MODE_RST  = 32'hFFFF_FFFF,
  parameter logic [31:0] SPEED_RST = 32'h0C00_0000,
  parameter logic [31:0] PULL_RST  = 32'h6400_0000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PINS-1:0]   pin_in_i,
  output logic [2*NUM_PINS-1:0] mode_o,
  output logic [NUM_PINS-1:0]   otype_o,
  output logic [2*NUM_PINS-1:0] speed_o,
  output logic [2*NUM_PINS-1:0] pull_o,
  output logic [NUM_PINS-1:0]   odata_o,
  output logic                  upd_o
);
  localparam int FW = 2 * NUM_PINS;
  localparam logic [NUM_REGS-1:0] UPD_MASK = ~(NUM_REGS'(1) << RI_IDATA);

  logic [NUM_REGS-1:0] sel, we;
  logic [DATA_W-1:0]   words [NUM_REGS];
  logic [NUM_PINS-1:0] lock_q, asw_q;
  logic [DATA_W-1:0]   aflo_q, afhi_q;
  logic                upd_q;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign we = sel & {NUM_REGS{wr_en_i}};

  // 2-bit-per-pin fields
  gpio_cfg_reg #(.WIDTH(FW), .RST(MODE_RST[FW-1:0])) u_mode (
    .clk_i, .rst_ni, .we_i(we[RI_MODE]), .d_i(wdata_i[FW-1:0]), .q_o(mode_o));
  gpio_cfg_reg #(.WIDTH(FW), .RST(SPEED_RST[FW-1:0])) u_speed (
    .clk_i, .rst_ni, .we_i(we[RI_SPEED]), .d_i(wdata_i[FW-1:0]), .q_o(speed_o));
  gpio_cfg_reg #(.WIDTH(FW), .RST(PULL_RST[FW-1:0])) u_pull (
    .clk_i, .rst_ni, .we_i(we[RI_PULL]), .d_i(wdata_i[FW-1:0]), .q_o(pull_o));

  // 1-bit-per-pin fields: upper half never stored
  gpio_cfg_reg #(.WIDTH(NUM_PINS), .RST('0)) u_otype (
    .clk_i, .rst_ni, .we_i(we[RI_OTYPE]), .d_i(wdata_i[NUM_PINS-1:0]), .q_o(otype_o));
  gpio_cfg_reg #(.WIDTH(NUM_PINS), .RST('0)) u_lock (
    .clk_i, .rst_ni, .we_i(we[RI_LOCK]), .d_i(wdata_i[NUM_PINS-1:0]), .q_o(lock_q));
  gpio_cfg_reg #(.WIDTH(NUM_PINS), .RST('0)) u_asw (
    .clk_i, .rst_ni, .we_i(we[RI_ASW]), .d_i(wdata_i[NUM_PINS-1:0]), .q_o(asw_q));

  // Alternate-function words: stored only
  gpio_cfg_reg #(.WIDTH(DATA_W), .RST('0)) u_aflo (
    .clk_i, .rst_ni, .we_i(we[RI_AFLO]), .d_i(wdata_i), .q_o(aflo_q));
  gpio_cfg_reg #(.WIDTH(DATA_W), .RST('0)) u_afhi (
    .clk_i, .rst_ni, .we_i(we[RI_AFHI]), .d_i(wdata_i), .q_o(afhi_q));

  gpio_odata_ctrl #(.NUM_PINS(NUM_PINS)) u_odata (
    .clk_i,
    .rst_ni,
    .wr_full_i (we[RI_ODATA]),
    .wr_bsr_i  (we[RI_BSR]),
    .wr_bclr_i (we[RI_BCLR]),
    .wdata_i   (wdata_i),
    .odata_o   (odata_o)
  );

  assign words[RI_MODE]  = DATA_W'(mode_o);
  assign words[RI_OTYPE] = DATA_W'(otype_o);
  assign words[RI_SPEED] = DATA_W'(speed_o);
  assign words[RI_PULL]  = DATA_W'(pull_o);
  assign words[RI_IDATA] = DATA_W'(pin_in_i);
  assign words[RI_ODATA] = DATA_W'(odata_o);
  assign words[RI_BSR]   = '0;
  assign words[RI_LOCK]  = DATA_W'(lock_q);
  assign words[RI_AFLO]  = aflo_q;
  assign words[RI_AFHI]  = afhi_q;
  assign words[RI_BCLR]  = '0;
  assign words[RI_ASW]   = DATA_W'(asw_q);

  gpio_rdata_mux u_rd (
    .clk_i,
    .rst_ni,
    .rd_en_i (rd_en_i),
    .sel_i   (sel),
    .words_i (words),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_q <= 1'b0;
    else         upd_q <= |(we & UPD_MASK);
  end
  assign upd_o = upd_q;
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_regs_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int ADDR_W   = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  wr_en_i,
  input logic                  rd_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [31:0]           wdata_i,
  input logic [31:0]           rdata_o,
  input logic [2*NUM_PINS-1:0] mode_o,
  input logic [NUM_PINS-1:0]   odata_o,
  input logic                  upd_o
);
  localparam logic [ADDR_W-1:0] A_IDATA = ADDR_W'(int'(RI_IDATA) * 4);
  localparam logic [ADDR_W-1:0] A_BSR   = ADDR_W'(int'(RI_BSR) * 4);
  localparam logic [ADDR_W-1:0] A_BCLR  = ADDR_W'(int'(RI_BCLR) * 4);

  logic in_map, wr_upd;
  assign in_map = (addr_i[1:0] == 2'b00) && (addr_i[ADDR_W-1:2] < (ADDR_W-2)'(NUM_REGS));
  assign wr_upd = wr_en_i && in_map && (addr_i != A_IDATA);

  // R4
  bsr_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_BSR) |=>
      ((odata_o & $past(wdata_i[NUM_PINS-1:0])) == $past(wdata_i[NUM_PINS-1:0])));

  // R5
  bclr_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_BCLR) |=> ((odata_o & $past(wdata_i[NUM_PINS-1:0])) == '0));

  // R6
  wo_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == A_BSR || addr_i == A_BCLR)) |=> (rdata_o == '0));

  // R8
  unmapped_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !in_map) |=> (rdata_o == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  // R10
  upd_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_upd |=> upd_o);

  // R10
  upd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_upd |=> !upd_o);

  // R7
  idata_write_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_IDATA) |=> ($stable(odata_o) && $stable(mode_o)));
endmodule

bind gpio_port_regs gpio_port_regs_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_gpio_port_regs.sv
module sim_gpio_port_regs;
  localparam int N = 16;
  localparam int AW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic [N-1:0]  pin_in_i = 16'h3C3C;
  logic [2*N-1:0] mode_o, speed_o, pull_o;
  logic [N-1:0]  otype_o, odata_o;
  logic          upd_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_port_regs u0 (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .pin_in_i, .mode_o, .otype_o, .speed_o, .pull_o, .odata_o, .upd_o
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h00, 32'h5555_0001, 32'h0,          "--"},
    '{1'b0, 8'h00, 32'h0,         32'h5555_0001, "R2"},
    '{1'b1, 8'h04, 32'hFFFF_00F0, 32'h0,          "--"},
    '{1'b0, 8'h04, 32'h0,         32'h0000_00F0, "R3"},
    '{1'b1, 8'h08, 32'h1234_5678, 32'h0,          "--"},
    '{1'b0, 8'h08, 32'h0,         32'h1234_5678, "R2"},
    '{1'b1, 8'h0C, 32'h8765_4321, 32'h0,          "--"},
    '{1'b0, 8'h0C, 32'h0,         32'h8765_4321, "R2"},
    '{1'b1, 8'h14, 32'hABCD_1234, 32'h0,          "--"},
    '{1'b0, 8'h14, 32'h0,         32'h0000_1234, "R3"},
    '{1'b1, 8'h18, 32'h00FF_0F00, 32'h0,          "--"},
    '{1'b0, 8'h14, 32'h0,         32'h0000_1F00, "R4"},
    '{1'b0, 8'h18, 32'h0,         32'h0,          "R6"},
    '{1'b1, 8'h18, 32'h8000_8000, 32'h0,          "--"},
    '{1'b0, 8'h14, 32'h0,         32'h0000_9F00, "R4"},
    '{1'b1, 8'h28, 32'hFFFF_1100, 32'h0,          "--"},
    '{1'b0, 8'h14, 32'h0,         32'h0000_8E00, "R5"},
    '{1'b0, 8'h28, 32'h0,         32'h0,          "R6"},
    '{1'b1, 8'h1C, 32'hFFFF_A5A5, 32'h0,          "--"},
    '{1'b0, 8'h1C, 32'h0,         32'h0000_A5A5, "R3"},
    '{1'b1, 8'h20, 32'hDEAD_BEEF, 32'h0,          "--"},
    '{1'b0, 8'h20, 32'h0,         32'hDEAD_BEEF, "R2"},
    '{1'b1, 8'h24, 32'hCAFE_F00D, 32'h0,          "--"},
    '{1'b0, 8'h24, 32'h0,         32'hCAFE_F00D, "R2"},
    '{1'b1, 8'h2C, 32'h1234_00FF, 32'h0,          "--"},
    '{1'b0, 8'h2C, 32'h0,         32'h0000_00FF, "R3"},
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0,          "--"},
    '{1'b0, 8'h10, 32'h0,         32'h0000_3C3C, "R7"},
    '{1'b0, 8'h14, 32'h0,         32'h0000_8E00, "R7"},
    '{1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0,          "--"},
    '{1'b0, 8'h30, 32'h0,         32'h0,          "R8"},
    '{1'b1, 8'h15, 32'h0000_0001, 32'h0,          "--"},
    '{1'b0, 8'h15, 32'h0,         32'h0,          "R8"},
    '{1'b0, 8'h14, 32'h0,         32'h0000_8E00, "R8"},
    '{1'b0, 8'h00, 32'h0,         32'h5555_0001, "R8"}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    do_read(8'h00, rd); check("R1 mode", rd, 32'hFFFF_FFFF);
    do_read(8'h04, rd); check("R1 otype", rd, 32'h0);
    do_read(8'h08, rd); check("R1 speed", rd, 32'h0C00_0000);
    do_read(8'h0C, rd); check("R1 pull", rd, 32'h6400_0000);
    do_read(8'h14, rd); check("R1 odata", rd, 32'h0);
    do_read(8'h1C, rd); check("R1 lock", rd, 32'h0);
    do_read(8'h20, rd); check("R1 aflo", rd, 32'h0);
    do_read(8'h24, rd); check("R1 afhi", rd, 32'h0);
    do_read(8'h2C, rd); check("R1 asw", rd, 32'h0);
    check("R1 upd_o", 32'(upd_o), 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) do_write(TBL[i].addr, TBL[i].data);
      else begin
        do_read(TBL[i].addr, rd);
        check(string'(TBL[i].tag), rd, TBL[i].exp);
      end
    end

    // R11 configuration outputs
    @(negedge clk_i);
    check("R11 mode_o", mode_o, 32'h5555_0001);
    check("R11 otype_o", 32'(otype_o), 32'h0000_00F0);
    check("R11 speed_o", speed_o, 32'h1234_5678);
    check("R11 pull_o", pull_o, 32'h8765_4321);
    check("R11 odata_o", 32'(odata_o), 32'h0000_8E00);

    // R7 input data follows pin_in_i
    pin_in_i = 16'hC3C3;
    do_read(8'h10, rd); check("R7 idata", rd, 32'h0000_C3C3);

    // R9 read hold and latency
    do_read(8'h08, rd);
    repeat (3) @(negedge clk_i);
    check("R9 hold", rdata_o, 32'h1234_5678);
    addr_i = 8'h0C; rd_en_i = 1'b1;
    #1 check("R9 no early change", rdata_o, 32'h1234_5678);
    @(negedge clk_i); rd_en_i = 1'b0;
    check("R9 after edge", rdata_o, 32'h8765_4321);

    // R10 update pulse
    do_write(8'h0C, 32'h0000_0001);
    check("R10 pulse", 32'(upd_o), 32'h1);
    @(negedge clk_i);
    check("R10 single", 32'(upd_o), 32'h0);
    do_write(8'h18, 32'h0000_0001);
    check("R10 bsr pulse", 32'(upd_o), 32'h1);
    do_write(8'h10, 32'h0000_FFFF);
    check("R10 idata none", 32'(upd_o), 32'h0);
    do_write(8'h40, 32'h0000_FFFF);
    check("R10 unmapped none", 32'(upd_o), 32'h0);
    check("R7 odata kept", 32'(odata_o), 32'h0000_8E01);

    // R5 clear with only upper half set: no change
    do_write(8'h28, 32'hFFFF_0000);
    check("R5 upper ignored", 32'(odata_o), 32'h0000_8E01);

    // R4 clear only
    do_write(8'h18, 32'h8001_0000);
    check("R4 clear", 32'(odata_o), 32'h0000_0E00);

    // R1 second reset
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    check("R1 mode_o again", mode_o, 32'hFFFF_FFFF);
    check("R1 odata_o again", 32'(odata_o), 32'h0);
    check("R1 rdata_o again", rdata_o, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule